// File: doc/BRIEF.md
# Bus Width Adapter for a 36-bit Word Port

This block sits between a 36-bit word memory port and an external data bus that may be 36, 18 or 9 bits wide. In the narrow widths, each memory word moves as a sequence of slices: two 18-bit halves or four 9-bit quarters. A 2-bit slice index walks through the pieces of each word. It counts upward when the least significant piece goes first and downward when the most significant piece goes first.

On writes, the slices collect in a staging register. The memory sees a single 36-bit write on the cycle of the final slice, carrying the fully assembled word. On reads, the memory word is fetched on the first slice and captured. The following slices are then cut from that captured copy.

Three static select inputs choose the bus width and the slice order. They pass through a register, so a change takes effect one cycle after it is applied. In the narrow widths, the bus lines that are not used are shown as undriven by a per-bit output-enable vector.

Top module: `bus_width_adapter`

## Requirements
- R1: Width decoding: `sel_narrow`=0 gives a 36-bit bus whatever `sel_byte` is. `sel_narrow`=1 with `sel_byte`=0 gives an 18-bit bus on bits 17:0. `sel_narrow`=1 with `sel_byte`=1 gives a 9-bit bus on bits 8:0. Write data on unused bus bits is ignored.
- R2: 18-bit mode: with `sel_msb_first`=0, bits 17:0 of the word move first and bits 35:18 second. With `sel_msb_first`=1, the order is reversed.
- R3: 9-bit mode: with `sel_msb_first`=0, the quarters move in the order 8:0, 17:9, 26:18, 35:27. With `sel_msb_first`=1, they move in exactly the reverse order.
- R4: 36-bit mode: every transfer moves a whole word and completes it, and `sel_msb_first` has no effect on data or timing.
- R5: A word takes 2 transfers in 18-bit mode and 4 in 9-bit mode. `word_done` is high during the transfer that carries the final slice, and the next transfer starts a new word.
- R6: On writes, `mem_wr` pulses only during the final slice of a word, and `mem_wdata` then holds the full assembled 36-bit word.
- R7: On reads, `mem_rd` pulses only during the first slice. `mem_rdata` is taken in that cycle, and the later slices of the word come from that copy even if `mem_rdata` changes.
- R8: `xfer_rdata_oe` is high only on the active bus bits, and only during a read transfer. Bits that are not enabled read as 0 on `xfer_rdata`.
- R9: A change on the select inputs takes effect one cycle later. A transfer in the cycle of the change still uses the old width, and the slice position restarts at the first slice of the new configuration.
- R10: After reset, the adapter is in 36-bit mode at the start of a word, with `mem_wr`, `mem_rd`, `word_done` and `xfer_rdata_oe` all low while no transfer is requested.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_narrow | input | 1 | 1 selects a narrow (18 or 9 bit) bus |
| sel_byte | input | 1 | With `sel_narrow`=1: 1 selects 9 bits, 0 selects 18 bits |
| sel_msb_first | input | 1 | 1 sends the most significant slice first |
| xfer_valid | input | 1 | One slice transfer in this cycle |
| xfer_write | input | 1 | 1 for a write slice, 0 for a read slice |
| xfer_wdata | input | 36 | Bus write data (low bits in narrow modes) |
| xfer_rdata | output | 36 | Bus read data (low bits in narrow modes) |
| xfer_rdata_oe | output | 36 | Per-bit drive enable for the read data |
| word_done | output | 1 | Final slice of a word transfers this cycle |
| mem_rd | output | 1 | Word read request toward memory |
| mem_wr | output | 1 | Word write strobe toward memory |
| mem_wdata | output | 36 | Assembled word toward memory |
| mem_rdata | input | 36 | Word from memory, valid in the `mem_rd` cycle |

## Verification
The bench covers all eight combinations of the three select inputs. In each one it writes and reads three different words, slice by slice. Every unused write bit carries a fixed filler, so a slice landing in the wrong lane or a leak from an unused line shows up as a wrong assembled word.

On reads, `mem_rdata` is inverted after the first slice. This tells apart a design that captures the word from one that keeps reading the live memory data. Comparing the two `sel_msb_first` values shows whether the slice index counts in the right direction, and in 36-bit mode it shows whether that input is truly ignored.

A separate pattern applies a width change together with a transfer in the same cycle. This checks the one-cycle delay of the selects and the restart of the slice position.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int SUB_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        BW_FULL    = 2'd0,
        BW_HALF    = 2'd1,
        BW_QUARTER = 2'd2
    } bw_mode_e;

    typedef struct packed {
        bw_mode_e mode;
        logic     msb_first;
    } bw_cfg_t;

    function automatic bw_mode_e decode_mode(input logic narrow, input logic byte_sel);
        if (!narrow)  return BW_FULL;
        if (byte_sel) return BW_QUARTER;
        return BW_HALF;
    endfunction

    function automatic logic [SUB_W-1:0] top_index(input bw_mode_e m);
        case (m)
            BW_HALF:    return SUB_W'(1);
            BW_QUARTER: return SUB_W'(LANES - 1);
            default:    return '0;
        endcase
    endfunction

    function automatic logic [SUB_W-1:0] first_index(input bw_cfg_t c);
        return c.msb_first ? top_index(c.mode) : '0;
    endfunction

    function automatic logic [SUB_W-1:0] final_index(input bw_cfg_t c);
        return c.msb_first ? '0 : top_index(c.mode);
    endfunction
endpackage

// File: rtl/bwa_cfg_reg.sv
module bwa_cfg_reg
    import bwa_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sel_narrow,
    input  logic    sel_byte,
    input  logic    sel_msb_first,
    output bw_cfg_t cfg_q,
    output bw_cfg_t cfg_d,
    output logic    cfg_change
);
    always_comb begin
        cfg_d.mode      = decode_mode(sel_narrow, sel_byte);
        cfg_d.msb_first = sel_msb_first && (cfg_d.mode != BW_FULL);
    end

    assign cfg_change = (cfg_d != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode      <= BW_FULL;
            cfg_q.msb_first <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/bwa_subctr.sv
module bwa_subctr
    import bwa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bw_cfg_t          cfg_q,
    input  bw_cfg_t          cfg_d,
    input  logic             cfg_change,
    input  logic             step,
    output logic [SUB_W-1:0] idx,
    output logic             is_first,
    output logic             is_last
);
    assign is_first = (idx == first_index(cfg_q));
    assign is_last  = (idx == final_index(cfg_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (cfg_change) begin
            idx <= first_index(cfg_d);
        end else if (step) begin
            if (is_last)              idx <= first_index(cfg_q);
            else if (cfg_q.msb_first) idx <= idx - 1'b1;
            else                      idx <= idx + 1'b1;
        end
    end

    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (rst)
        cfg_q.mode == BW_HALF |-> idx <= SUB_W'(1)); // R5
    AST_RESTART_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        step && is_last && !cfg_change |=> is_first); // R5
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
        step && !is_last && !cfg_change && !cfg_q.msb_first |=> idx == SUB_W'($past(idx) + 1'b1)); // R5
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        step && !is_last && !cfg_change && cfg_q.msb_first |=> idx == SUB_W'($past(idx) - 1'b1)); // R5
    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (rst)
        cfg_change |=> is_first); // R9
endmodule

// File: rtl/bwa_pack.sv
module bwa_pack
    import bwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bw_cfg_t           cfg_q,
    input  logic [SUB_W-1:0]  idx,
    input  logic              wr_slice,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] word_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HALF_POS = k / 2;
        localparam int HALF_SRC = k % 2;
        logic              hit;
        int                src;
        logic [LANE_W-1:0] in_lane;
        logic [LANE_W-1:0] stage;

        always_comb begin
            case (cfg_q.mode)
                BW_HALF: begin
                    hit = (int'(idx) == HALF_POS);
                    src = HALF_SRC;
                end
                BW_QUARTER: begin
                    hit = (int'(idx) == k);
                    src = 0;
                end
                default: begin
                    hit = 1'b1;
                    src = k;
                end
            endcase
            in_lane = bus_wdata[src*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)                 stage <= '0;
            else if (wr_slice && hit) stage <= in_lane;
        end

        assign word_out[k*LANE_W +: LANE_W] = (wr_slice && hit) ? in_lane : stage;
    end
endmodule

// File: rtl/bwa_slice.sv
module bwa_slice
    import bwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bw_cfg_t           cfg_q,
    input  logic [SUB_W-1:0]  idx,
    input  logic              is_first,
    input  logic              rd_slice,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] bus_oe
);
    logic [WORD_W-1:0] hold;
    logic [WORD_W-1:0] src_word;

    always_ff @(posedge clk) begin
        if (rst)                       hold <= '0;
        else if (rd_slice && is_first) hold <= mem_rdata;
    end

    assign src_word = is_first ? mem_rdata : hold;

    for (genvar j = 0; j < LANES; j++) begin : g_out
        logic en;
        int   sl;

        always_comb begin
            case (cfg_q.mode)
                BW_HALF:    en = (j < 2);
                BW_QUARTER: en = (j == 0);
                default:    en = 1'b1;
            endcase
            if (!en)                         sl = 0;
            else if (cfg_q.mode == BW_HALF)    sl = int'(idx) * 2 + j;
            else if (cfg_q.mode == BW_QUARTER) sl = int'(idx);
            else                             sl = j;
        end

        assign bus_rdata[j*LANE_W +: LANE_W] = en ? src_word[sl*LANE_W +: LANE_W] : '0;
        assign bus_oe[j*LANE_W +: LANE_W]    = {LANE_W{en && rd_slice}};
    end

    AST_OE_QUARTER: assert property (@(posedge clk) disable iff (rst)
        cfg_q.mode == BW_QUARTER |-> bus_oe[WORD_W-1:LANE_W] == '0); // R8
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_slice |-> bus_oe == '0); // R8
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_narrow,
    input  logic              sel_byte,
    input  logic              sel_msb_first,
    input  logic              xfer_valid,
    input  logic              xfer_write,
    input  logic [WORD_W-1:0] xfer_wdata,
    output logic [WORD_W-1:0] xfer_rdata,
    output logic [WORD_W-1:0] xfer_rdata_oe,
    output logic              word_done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    bw_cfg_t          cfg_q;
    bw_cfg_t          cfg_d;
    logic             cfg_change;
    logic [SUB_W-1:0] idx;
    logic             is_first;
    logic             is_last;
    logic             wr_slice;
    logic             rd_slice;

    assign wr_slice = xfer_valid && xfer_write;
    assign rd_slice = xfer_valid && !xfer_write;

    bwa_cfg_reg u_cfg (
        .clk(clk), .rst(rst),
        .sel_narrow(sel_narrow), .sel_byte(sel_byte), .sel_msb_first(sel_msb_first),
        .cfg_q(cfg_q), .cfg_d(cfg_d), .cfg_change(cfg_change)
    );

    bwa_subctr u_sub (
        .clk(clk), .rst(rst),
        .cfg_q(cfg_q), .cfg_d(cfg_d), .cfg_change(cfg_change),
        .step(xfer_valid), .idx(idx), .is_first(is_first), .is_last(is_last)
    );

    bwa_pack u_pack (
        .clk(clk), .rst(rst), .cfg_q(cfg_q), .idx(idx),
        .wr_slice(wr_slice), .bus_wdata(xfer_wdata), .word_out(mem_wdata)
    );

    bwa_slice u_slice (
        .clk(clk), .rst(rst), .cfg_q(cfg_q), .idx(idx), .is_first(is_first),
        .rd_slice(rd_slice), .mem_rdata(mem_rdata),
        .bus_rdata(xfer_rdata), .bus_oe(xfer_rdata_oe)
    );

    assign word_done = xfer_valid && is_last;
    assign mem_wr    = wr_slice && is_last;
    assign mem_rd    = rd_slice && is_first;

    AST_WR_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> word_done); // R6
    AST_FULL_EVERY: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && cfg_q.mode == BW_FULL |-> word_done); // R4
    AST_RD_NOT_WR: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R7
endmodule

// File: tb/bus_width_adapter_tb.sv
module bus_width_adapter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_narrow = 1'b0, sel_byte = 1'b0, sel_msb_first = 1'b0;
    logic        xfer_valid = 1'b0, xfer_write = 1'b0;
    logic [35:0] xfer_wdata = '0;
    logic [35:0] xfer_rdata, xfer_rdata_oe, mem_wdata;
    logic [35:0] mem_rdata = '0;
    logic        word_done, mem_rd, mem_wr;
    int          checks = 0, failures = 0;
    bit          finished = 0;

    localparam logic [35:0] FILLER = 36'hF_0F0F_0F0F;

    always #5 clk = ~clk;

    bus_width_adapter u_dut (
        .clk(clk), .rst(rst), .sel_narrow(sel_narrow), .sel_byte(sel_byte),
        .sel_msb_first(sel_msb_first), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
        .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata), .xfer_rdata_oe(xfer_rdata_oe),
        .word_done(word_done), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic n, input logic b, input logic e);
        @(posedge clk); #1;
        sel_narrow = n; sel_byte = b; sel_msb_first = e;
        xfer_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic write_word(input string req, input int sw, input logic e, input logic [35:0] w);
        int          ns = 36 / sw;
        logic [35:0] mask = (sw == 36) ? '1 : ((36'd1 << sw) - 36'd1);
        for (int s = 0; s < ns; s++) begin
            int p = e ? ns - 1 - s : s;
            @(posedge clk); #1;
            xfer_valid = 1'b1; xfer_write = 1'b1;
            xfer_wdata = ((w >> (p * sw)) & mask) | (FILLER & ~mask);
            #7;
            chk({req, " R5 word_done"}, 36'(word_done), 36'(s == ns - 1));
            chk({req, " R6 mem_wr"},    36'(mem_wr),    36'(s == ns - 1));
            if (s == ns - 1) chk({req, " R6 mem_wdata"}, mem_wdata, w);
        end
        @(posedge clk); #1;
        xfer_valid = 1'b0;
    endtask

    task automatic read_word(input string req, input int sw, input logic e, input logic [35:0] w);
        int          ns = 36 / sw;
        logic [35:0] mask = (sw == 36) ? '1 : ((36'd1 << sw) - 36'd1);
        for (int s = 0; s < ns; s++) begin
            int p = e ? ns - 1 - s : s;
            @(posedge clk); #1;
            xfer_valid = 1'b1; xfer_write = 1'b0;
            mem_rdata = (s == 0) ? w : ~w;
            #7;
            chk({req, " R7 mem_rd"},       36'(mem_rd), 36'(s == 0));
            chk({req, " data"},            xfer_rdata, (w >> (p * sw)) & mask);
            chk({req, " R1 R8 oe"},        xfer_rdata_oe, mask);
            chk({req, " R5 word_done rd"}, 36'(word_done), 36'(s == ns - 1));
        end
        @(posedge clk); #1;
        xfer_valid = 1'b0;
        #7;
        chk("R8 oe idle", xfer_rdata_oe, '0);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        #7;
        chk("R10 word_done", 36'(word_done), '0);
        chk("R10 mem_wr", 36'(mem_wr), '0);
        chk("R10 mem_rd", 36'(mem_rd), '0);
        chk("R10 oe", xfer_rdata_oe, '0);
        write_word("R10 full after reset", 36, 1'b0, 36'h5_A5A5_A5A5);

        for (int ci = 0; ci < 8; ci++) begin
            logic n = ci[2], b = ci[1], e = ci[0];
            int   sw = !n ? 36 : (b ? 9 : 18);
            string req = (sw == 36) ? (e ? "R4" : "R1") : (sw == 18 ? "R2" : "R3");
            set_mode(n, b, e);
            for (int k = 0; k < 3; k++) begin
                logic [35:0] w = 36'h0_1234_5678 + 36'(k) * 36'h9_ABCD_EF01 + 36'(ci) * 36'h1_1111_1111;
                write_word(req, sw, e, w);
                read_word(req, sw, e, w ^ 36'h3_0C30_C30C);
            end
        end

        set_mode(1'b1, 1'b1, 1'b0);
        @(posedge clk); #1;
        sel_narrow = 1'b0; sel_byte = 1'b0;
        xfer_valid = 1'b1; xfer_write = 1'b1; xfer_wdata = 36'h1_2345_6789;
        #7;
        chk("R9 old width word_done", 36'(word_done), '0);
        chk("R9 old width mem_wr", 36'(mem_wr), '0);
        @(posedge clk); #1;
        xfer_wdata = 36'h9_8765_4321;
        #7;
        chk("R9 new width mem_wr", 36'(mem_wr), 36'd1);
        chk("R9 new width data", mem_wdata, 36'h9_8765_4321);
        @(posedge clk); #1;
        xfer_valid = 1'b0;

        set_mode(1'b1, 1'b1, 1'b0);
        write_word("R9 partial", 9, 1'b0, 36'h0_0000_0000);
        set_mode(1'b1, 1'b0, 1'b1);
        write_word("R9 restart", 18, 1'b1, 36'hC_3C3C_3C3C);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule